// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a data word by a number of clock cycles chosen at run time through a 6-bit delay select. The path is a cascade of six shift-register segments holding 1, 2, 4, 8, 16 and 32 stages. Each segment sits beside a 2:1 bypass multiplexer. Bit k of the delay select puts the segment of length 2^k into the path. The total delay is therefore the unsigned value of the select word, anywhere from 0 to 63 cycles.

Every segment shifts on every clock, whether or not its multiplexer routes data through it. A segment that is switched in therefore already holds the words that reached its input. With a select of zero, no register lies in the path and the output follows the input combinationally.

A change of the delay select while data is flowing is not glitch-free. The output matches the new delay once the new delay plus 63 cycles have passed. The data width is a parameter, 1 bit by default. All segment registers clear to zero on reset.

Top module: `binw_delay_line`

## Requirements
- R1: With `dly_sel` held at value d for at least d+63 cycles, `dout` equals the `din` word captured d rising edges earlier, for every d from 0 to 63, with each data bit carried independently.
- R2: With `dly_sel` equal to 0, `dout` equals `din` in the same cycle, through no register. This holds during reset as well.
- R3: Bit k of `dly_sel` (k = 0 for the least significant bit) inserts exactly 2^k stages. A select with only bit k set gives a delay of 2^k cycles.
- R4: The largest select value, 63, gives a delay of 63 cycles.
- R5: While `rst_n` is low, and afterwards until input data has had time to reach the output, every segment register reads zero. With a nonzero select, `dout` is zero during reset and during the first cycles after release. With a select of 63, this lasts for at least 32 cycles.
- R6: A segment that is bypassed keeps shifting its input. After `dly_sel` has been 0 for at least 63 cycles, switching it to a single bit 2^k gives the correctly delayed word on `dout` in the very first cycle after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all segment registers shift on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears every segment register |
| din | input | DATA_W | Data word entering the line |
| dly_sel | input | CTRL_W | Delay select; unsigned number of cycles, bit k switches in the 2^k-stage segment |
| dout | output | DATA_W | Delayed data word |

## Verification
A wrong register in a segment shows at `dout` only while that segment is switched in, and only after the corrupted word has walked to the segment's last stage. For segment k, that takes up to 2^k cycles, plus the delay of the segments downstream. The bench therefore compares `dout` with a reference history after a full settling window for every select value. It also checks the first cycle after switching from zero to each single-bit select, which exposes a segment that stalls while bypassed. It checks the all-zero output right after reset and the combinational path at select zero, which expose a wrong clear value and a stray register.

// File: rtl/binw_delay_pkg.sv
package binw_delay_pkg;
  // length of segment k in stages
  function automatic int seg_len(input int k);
    return 1 << k;
  endfunction

  // total stages when every segment is in the path
  function automatic int max_delay(input int nseg);
    return (1 << nseg) - 1;
  endfunction
endpackage

// File: rtl/binw_delay_seg.sv
module binw_delay_seg #(
  parameter int DATA_W = 1,
  parameter int LEN    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] seg_in,
  output logic [DATA_W-1:0] seg_out
);
  localparam int LAST = LEN - 1;

  logic [DATA_W-1:0] stage_q [LEN];
  logic [DATA_W-1:0] stage_d [LEN];

  // next-state: shift by one position toward the output
  always_comb begin
    for (int i = 0; i < LEN; i++) begin
      if (!shift_en) begin
        stage_d[i] = stage_q[i];
      end else if (i == 0) begin
        stage_d[i] = seg_in;
      end else begin
        stage_d[i] = stage_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LEN; i++) stage_q[i] <= '0;
    end else begin
      for (int i = 0; i < LEN; i++) stage_q[i] <= stage_d[i];
    end
  end

  assign seg_out = stage_q[LAST];
endmodule

// File: rtl/binw_delay_bypass.sv
module binw_delay_bypass #(
  parameter int DATA_W = 1
) (
  input  logic              use_seg,
  input  logic [DATA_W-1:0] thru_val,
  input  logic [DATA_W-1:0] skip_val,
  output logic [DATA_W-1:0] sel_val
);
  always_comb begin
    if (use_seg) sel_val = thru_val;
    else         sel_val = skip_val;
  end
endmodule

// File: rtl/binw_delay_line.sv
module binw_delay_line
  import binw_delay_pkg::*;
#(
  parameter int DATA_W = 1,
  parameter int CTRL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic [CTRL_W-1:0] dly_sel,
  output logic [DATA_W-1:0] dout
);
  localparam int NSEG = CTRL_W;

  // node k is the input of segment k; node NSEG is the line output
  logic [DATA_W-1:0] node [NSEG+1];
  logic [DATA_W-1:0] seg_q [NSEG];

  assign node[0] = din;

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    // segments shift unconditionally so bypassed ones stay current
    binw_delay_seg #(
      .DATA_W (DATA_W),
      .LEN    (seg_len(k))
    ) u_seg (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (1'b1),
      .seg_in   (node[k]),
      .seg_out  (seg_q[k])
    );

    binw_delay_bypass #(
      .DATA_W (DATA_W)
    ) u_byp (
      .use_seg  (dly_sel[k]),
      .thru_val (seg_q[k]),
      .skip_val (node[k]),
      .sel_val  (node[k+1])
    );
  end

  assign dout = node[NSEG];
endmodule

// File: rtl/binw_delay_line_chk.sv
module binw_delay_line_chk #(
  parameter int DATA_W = 1,
  parameter int CTRL_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] din,
  input logic [CTRL_W-1:0] dly_sel,
  input logic [DATA_W-1:0] dout
);
  // edges seen since reset release, saturating
  logic [6:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             age_q <= '0;
    else if (age_q != 7'h7f) age_q <= age_q + 7'd1;
  end

  // R2: zero select is a combinational pass-through
  always_comb begin
    if (dly_sel == '0) begin
      a_r2_zero_passthru: assert (dout == din);
    end
  end

  // R3: lowest bit alone gives one stage
  a_r3_one_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_sel == CTRL_W'(1) && age_q >= 7'd1) |-> dout == $past(din));

  // R3: second bit alone gives two stages
  a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_sel == CTRL_W'(2) && age_q >= 7'd2) |-> dout == $past(din, 2));

  // R5: nothing but the reset value can reach the output at the first edge
  a_r5_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 7'd0 && dly_sel != '0) |-> dout == '0);

  // R5: the longest segment drains zeros for its full length
  a_r5_long_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_sel[CTRL_W-1] && age_q < 7'd32) |-> dout == '0);

  // R6: bypassed one-stage segment already holds the last input when switched in
  a_r6_switch_in: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 7'd1 && dly_sel == CTRL_W'(1) && $past(dly_sel) == '0)
      |-> dout == $past(din));
endmodule

bind binw_delay_line binw_delay_line_chk #(
  .DATA_W (DATA_W),
  .CTRL_W (CTRL_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .din     (din),
  .dly_sel (dly_sel),
  .dout    (dout)
);

// File: tb/binw_delay_line_tb.sv
`timescale 1ns/1ps
module binw_delay_line_tb;
  localparam int W  = 8;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  din = '0;
  logic [CW-1:0] dly_sel = '0;
  logic [W-1:0]  dout;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  binw_delay_line #(.DATA_W(W), .CTRL_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .dly_sel(dly_sel), .dout(dout));

  // reference: hist[i] = din captured i+1 rising edges ago (zero before reset release)
  logic [W-1:0] hist [64];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) hist[i] <= '0;
    end else begin
      for (int i = 63; i > 0; i--) hist[i] <= hist[i-1];
      hist[0] <= din;
    end
  end

  function automatic logic [W-1:0] exp_out(input int d);
    if (d == 0) return din;
    return hist[d-1];
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    n_tests++;
    if (dout !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", req, dly_sel, dout, exp);
    end
  endtask

  // advance one cycle: new data at the falling edge, settle briefly
  task automatic step();
    @(negedge clk);
    din = W'($urandom);
    #1;
  endtask

  task automatic settle(input int d);
    @(negedge clk);
    dly_sel = CW'(d);
    repeat (d + 63) step();
  endtask

  initial begin
    #900000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    // reset behaviour
    dly_sel = 6'd5; din = 8'hA5;
    repeat (3) @(negedge clk);
    #1 check("R5", '0);
    dly_sel = '0; #1 check("R2", din);
    din = 8'h3C; #1 check("R2", din);
    dly_sel = 6'd63;
    @(negedge clk); rst_n = 1'b1;
    // maximum delay from reset: zeros drain first, then delayed data
    for (int c = 0; c < 40; c++) begin
      step();
      check("R5", exp_out(63));
      if (c < 31 && dout !== '0) begin
        n_tests++; n_fail++;
        $display("FAIL R5 early nonzero actual=%h expected=%h", dout, 8'h00);
      end
    end
    for (int c = 0; c < 60; c++) begin step(); check("R4", exp_out(63)); end

    // combinational path at zero select
    @(negedge clk); dly_sel = '0;
    for (int c = 0; c < 20; c++) begin step(); check("R2", din); end

    // single-bit selects, checked right after switching in from zero
    for (int k = 0; k < CW; k++) begin
      @(negedge clk); dly_sel = '0;
      repeat (64) step();
      @(negedge clk);
      dly_sel = CW'(1 << k);
      din = W'($urandom);
      #1 check("R6", exp_out(1 << k));
      for (int c = 0; c < 70; c++) begin step(); check("R3", exp_out(1 << k)); end
    end

    // directed mixed values and random selects
    for (int t = 0; t < 26; t++) begin
      int d;
      case (t)
        0: d = 63;
        1: d = 37;
        2: d = 42;
        3: d = 21;
        4: d = 0;
        5: d = 3;
        default: d = $urandom_range(0, 63);
      endcase
      settle(d);
      for (int c = 0; c < 12; c++) begin step(); check("R1", exp_out(d)); end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule